// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block follows a chain of transmit descriptors held in system memory and turns each one into the per-packet data a transmit DMA engine needs. Each descriptor is a run of 16-bit words. Every field address is a fixed upper segment joined with a 16-bit offset. The walker reads a descriptor's fields through a single request/acknowledge memory port. It issues a one-cycle header pulse that carries the packet's mode word, its length and its fragment count. It then hands each fragment's 32-bit pointer and size to a downstream consumer through a valid/ready pair.

When the consumer reports that the packet has gone out, the walker writes the reported status into the descriptor's first word. It then reads the link word. An odd link ends the walk with a one-cycle done pulse. An even link is taken as the offset of the next descriptor. A descriptor that declares zero fragments gets an error status written back, produces no header or fragments, and has its link taken from the word just after the count.

Descriptor layout, in words from the descriptor offset: 0 status, 1 mode word, 2 packet length, 3 fragment count, then one triple per fragment (pointer low, pointer high, size) starting at word 4, and the link word at 4 + 3·count.

Top module: `tx_desc_walker`

## Requirements
- R1: While reset is held and after it is released, `busy`, `mem_req`, `frag_valid`, `hdr_valid` and `list_done` are low.
- R2: Every memory address equals {the `upper_seg` value captured at `start`, descriptor offset + 2·word index}, so address bit 0 is always 0. The low 16 bits wrap modulo 2^16.
- R3: A descriptor begins with exactly six reads, at word indices 1 to 6 in that order. The first fragment is presented only after the sixth read has been acknowledged.
- R4: Each fragment after the first costs exactly three reads, at the next three word indices (pointer low, pointer high, size). Fragments are presented with `frag_ptr` = {high, low}, and `frag_last` is high only on the final fragment.
- R5: After the first six reads of a descriptor with a nonzero count, `hdr_valid` is high for exactly one cycle. During that cycle `hdr_cfg`, `hdr_size` and `hdr_frags` carry words 1, 2 and 3.
- R6: Once `mem_req` is raised, it stays high, together with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` is seen, however many cycles that takes. Only one access is outstanding at a time.
- R7: After the last fragment is accepted, the walker waits for `tx_done`. It then performs one write of `tx_status` to word 0 of the descriptor.
- R8: After the status write, the link word at index 4 + 3·count is read. If the link's bit 0 is 1, `list_done` pulses for one cycle and `busy` falls in the same cycle. Otherwise the walk continues with the link value as the new descriptor offset.
- R9: A fragment count of 0 writes `ERR_STATUS` to word 0, presents no header or fragment, and reads the link at word index 4.
- R10: `tx_done` is ignored unless the walker is waiting for a completion, and `start` is ignored while `busy` is high.
- R11: While `frag_valid` is high and `frag_ready` is low, `frag_valid`, `frag_ptr`, `frag_size` and `frag_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at `desc_off` (ignored when busy) |
| upper_seg | input | SEG_W | Upper address segment, captured at start |
| desc_off | input | OFF_W | Offset of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | SEG_W+OFF_W | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | DW | Read data |
| hdr_valid | output | 1 | One-cycle packet header pulse |
| hdr_cfg | output | DW | Per-packet mode word |
| hdr_size | output | DW | Packet length word |
| hdr_frags | output | DW | Fragment count |
| frag_valid | output | 1 | Fragment tuple valid |
| frag_ready | input | 1 | Consumer accepts the fragment |
| frag_ptr | output | 2*DW | Fragment buffer pointer |
| frag_size | output | DW | Fragment size |
| frag_last | output | 1 | Final fragment of the packet |
| tx_done | input | 1 | Packet transmission finished |
| tx_status | input | DW | Status to write back |
| busy | output | 1 | Walk in progress |
| list_done | output | 1 | One-cycle end-of-list pulse |
| cur_off | output | OFF_W | Offset of the current descriptor |

## Verification
The bench uses the default 16-bit segment, offset and data widths, with `ERR_STATUS` set to 16'h8001. A nonzero segment (16'h1234) makes any slip in the address join visible. The chain runs twice: once with the fastest memory and an always-ready consumer, and once with three extra wait states and a consumer that toggles its ready. This covers held requests, stalled fragments, one- and multi-fragment packets, and the zero-count error path in a single list. A `start` pulse during a walk and a stray `tx_done` while idle test the ignore rules at the memory port.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST,
    ST_FRAG_RD,
    ST_FRAG_OUT,
    ST_WAIT_TX,
    ST_WR_STAT,
    ST_RD_LINK
  } tdf_state_e;

  localparam int unsigned BURST_FIRST = 1;
  localparam int unsigned BURST_LAST  = 6;
  localparam int unsigned LINK_NOFRAG = 4;
  localparam int unsigned FRAG2_FIRST = 7;
endpackage

// File: rtl/tdf_addr_gen.sv
module tdf_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16
) (
  input  logic [SEG_W-1:0]       seg,
  input  logic [OFF_W-1:0]       base,
  input  logic [OFF_W-1:0]       word_idx,
  output logic [SEG_W+OFF_W-1:0] addr
);
  logic [OFF_W-1:0] low;

  always_comb begin
    low  = base + (word_idx << 1);
    addr = {seg, low};
  end
endmodule

// File: rtl/tdf_mem_port.sv
module tdf_mem_port #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_wdata,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          xfer_done
);
  assign xfer_done = mem_req & mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (xfer_done) begin
      mem_req <= 1'b0;
    end else if (issue && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= issue_we;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end
  end
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tdf_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int DW    = 16,
  parameter logic [DW-1:0] ERR_STATUS = 16'h8001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [SEG_W-1:0]       upper_seg,
  input  logic [OFF_W-1:0]       desc_off,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [SEG_W+OFF_W-1:0] mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   hdr_valid,
  output logic [DW-1:0]          hdr_cfg,
  output logic [DW-1:0]          hdr_size,
  output logic [DW-1:0]          hdr_frags,
  output logic                   frag_valid,
  input  logic                   frag_ready,
  output logic [2*DW-1:0]        frag_ptr,
  output logic [DW-1:0]          frag_size,
  output logic                   frag_last,
  input  logic                   tx_done,
  input  logic [DW-1:0]          tx_status,
  output logic                   busy,
  output logic                   list_done,
  output logic [OFF_W-1:0]       cur_off
);
  localparam int AW = SEG_W + OFF_W;
  localparam logic [OFF_W-1:0] IDX_FIRST  = OFF_W'(BURST_FIRST);
  localparam logic [OFF_W-1:0] IDX_LAST   = OFF_W'(BURST_LAST);
  localparam logic [OFF_W-1:0] IDX_NOFRAG = OFF_W'(LINK_NOFRAG);
  localparam logic [OFF_W-1:0] IDX_FRAG2  = OFF_W'(FRAG2_FIRST);
  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(1);

  tdf_state_e       state;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] base_q, idx_q;
  logic [1:0]       sub_q;
  logic [DW-1:0]    cfg_q, size_q, cnt_q, plo_q, phi_q, fsz_q, rem_q, stat_q;
  logic             hdr_q, done_q;

  logic             acc_active, acc_we, issue, xfer_done;
  logic [OFF_W-1:0] acc_idx;
  logic [AW-1:0]    acc_addr;

  always_comb begin
    acc_active = (state == ST_BURST) || (state == ST_FRAG_RD) ||
                 (state == ST_WR_STAT) || (state == ST_RD_LINK);
    acc_we     = (state == ST_WR_STAT);
    acc_idx    = acc_we ? '0 : idx_q;
    issue      = acc_active && !mem_req;
  end

  tdf_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_addr (
    .seg      (seg_q),
    .base     (base_q),
    .word_idx (acc_idx),
    .addr     (acc_addr)
  );

  tdf_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .issue_we    (acc_we),
    .issue_addr  (acc_addr),
    .issue_wdata (stat_q),
    .mem_ack     (mem_ack),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .xfer_done   (xfer_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      seg_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
      sub_q  <= '0;
      cfg_q  <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      fsz_q  <= '0;
      rem_q  <= '0;
      stat_q <= '0;
      hdr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hdr_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            seg_q  <= upper_seg;
            base_q <= desc_off & ALIGN_MASK;
            idx_q  <= IDX_FIRST;
            state  <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (xfer_done) begin
            unique case (idx_q[2:0])
              3'd1:    cfg_q  <= mem_rdata;
              3'd2:    size_q <= mem_rdata;
              3'd3:    cnt_q  <= mem_rdata;
              3'd4:    plo_q  <= mem_rdata;
              3'd5:    phi_q  <= mem_rdata;
              default: fsz_q  <= mem_rdata;
            endcase
            if (idx_q == IDX_LAST) begin
              if (cnt_q == '0) begin
                stat_q <= ERR_STATUS;
                idx_q  <= IDX_NOFRAG;
                state  <= ST_WR_STAT;
              end else begin
                hdr_q  <= 1'b1;
                rem_q  <= cnt_q;
                idx_q  <= IDX_FRAG2;
                state  <= ST_FRAG_OUT;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_FRAG_RD: begin
          if (xfer_done) begin
            unique case (sub_q)
              2'd0:    plo_q <= mem_rdata;
              2'd1:    phi_q <= mem_rdata;
              default: fsz_q <= mem_rdata;
            endcase
            idx_q <= idx_q + 1'b1;
            if (sub_q == 2'd2) state <= ST_FRAG_OUT;
            else               sub_q <= sub_q + 1'b1;
          end
        end
        ST_FRAG_OUT: begin
          if (frag_ready) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == DW'(1)) begin
              state <= ST_WAIT_TX;
            end else begin
              sub_q <= '0;
              state <= ST_FRAG_RD;
            end
          end
        end
        ST_WAIT_TX: begin
          if (tx_done) begin
            stat_q <= tx_status;
            state  <= ST_WR_STAT;
          end
        end
        ST_WR_STAT: begin
          if (xfer_done) state <= ST_RD_LINK;
        end
        default: begin
          if (xfer_done) begin
            if (mem_rdata[0]) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              base_q <= OFF_W'(mem_rdata);
              idx_q  <= IDX_FIRST;
              state  <= ST_BURST;
            end
          end
        end
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign list_done  = done_q;
  assign cur_off    = base_q;
  assign hdr_valid  = hdr_q;
  assign hdr_cfg    = cfg_q;
  assign hdr_size   = size_q;
  assign hdr_frags  = cnt_q;
  assign frag_valid = (state == ST_FRAG_OUT);
  assign frag_ptr   = {phi_q, plo_q};
  assign frag_size  = fsz_q;
  assign frag_last  = (rem_q == DW'(1));
endmodule

// File: rtl/tx_desc_walker_chk.sv
module tx_desc_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          hdr_valid,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic [2*DW-1:0] frag_ptr,
  input logic [DW-1:0] frag_size,
  input logic          frag_last,
  input logic          list_done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !frag_valid));

  p_word_align_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  p_no_access_while_frag_r3: assert property (@(posedge clk) disable iff (rst)
    frag_valid |-> !mem_req);

  p_hdr_single_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> !hdr_valid);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    list_done |-> !busy);

  p_frag_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_ptr) &&
                                     $stable(frag_size) && $stable(frag_last)));
endmodule

bind tx_desc_walker tx_desc_walker_chk #(.AW(SEG_W + OFF_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .hdr_valid  (hdr_valid),
  .frag_valid (frag_valid),
  .frag_ready (frag_ready),
  .frag_ptr   (frag_ptr),
  .frag_size  (frag_size),
  .frag_last  (frag_last),
  .list_done  (list_done)
);

// File: tb/tx_desc_walker_bench.sv
module tx_desc_walker_bench;
  localparam logic [15:0] SEG = 16'h1234;
  localparam logic [15:0] ERR = 16'h8001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] upper_seg = SEG;
  logic [15:0] desc_off = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        hdr_valid, frag_valid, frag_last, frag_ready = 1'b1;
  logic [15:0] hdr_cfg, hdr_size, hdr_frags, frag_size;
  logic [31:0] frag_ptr;
  logic        tx_done = 1'b0;
  logic [15:0] tx_status = '0;
  logic        busy, list_done;
  logic [15:0] cur_off;

  always #5 clk = ~clk;

  tx_desc_walker #(.ERR_STATUS(ERR)) u_tx_desc_walker (
    .clk(clk), .rst(rst), .start(start), .upper_seg(upper_seg), .desc_off(desc_off),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hdr_valid(hdr_valid), .hdr_cfg(hdr_cfg), .hdr_size(hdr_size), .hdr_frags(hdr_frags),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_ptr(frag_ptr),
    .frag_size(frag_size), .frag_last(frag_last),
    .tx_done(tx_done), .tx_status(tx_status),
    .busy(busy), .list_done(list_done), .cur_off(cur_off)
  );

  int checks = 0;
  int fails  = 0;
  int wait_n = 0;
  int ready_mode = 0;
  int acc_count = 0;
  int done_count = 0;
  int pk = 0;
  logic [15:0] mem [0:255];
  logic [48:0] exp_acc [$];
  logic [47:0] exp_hdr [$];
  logic [48:0] exp_frag [$];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with a programmable number of extra wait states
  int wcnt = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= wait_n) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[8:1]];
        if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        wcnt <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // consumer ready pattern
  initial forever begin
    @(posedge clk);
    #2 frag_ready = (ready_mode != 0) ? ~frag_ready : 1'b1;
  end

  // completion reporter
  initial forever begin
    @(negedge clk);
    if (frag_valid && frag_ready && frag_last) begin
      @(posedge clk);
      #2 tx_done = 1'b1;
      tx_status = 16'h5000 + 16'(pk);
      pk++;
      @(posedge clk);
      #2 tx_done = 1'b0;
    end
  end

  // monitors: pop expected items as results appear
  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      acc_count++;
      if (exp_acc.size() == 0) begin
        check("R3", "unexpected access", {15'd0, mem_we, mem_addr, mem_wdata}, 64'd0);
      end else begin
        logic [48:0] e;
        e = exp_acc.pop_front();
        check("R2", "access we/addr", {31'd0, mem_we, mem_addr}, {31'd0, e[48:16]});
        if (e[48]) check("R7", "write data", 64'(mem_wdata), 64'(e[15:0]));
      end
    end
    if (hdr_valid) begin
      if (exp_hdr.size() == 0) check("R9", "unexpected header", 64'(hdr_frags), 64'hFFFF);
      else check("R5", "header fields", {16'd0, hdr_cfg, hdr_size, hdr_frags},
                 {16'd0, exp_hdr.pop_front()});
    end
    if (frag_valid && frag_ready) begin
      if (exp_frag.size() == 0) check("R4", "unexpected fragment", 64'(frag_ptr), 64'd0);
      else check("R4", "fragment tuple", {15'd0, frag_ptr, frag_size, frag_last},
                 {15'd0, exp_frag.pop_front()});
    end
    if (list_done) begin
      done_count++;
      check("R8", "busy low with list_done", 64'(busy), 64'd0);
    end
  end

  task automatic push_acc(input logic we, input logic [15:0] off,
                          input int idx, input logic [15:0] wd);
    logic [15:0] lo;
    lo = off + 16'(2 * idx);
    exp_acc.push_back({we, SEG, lo, wd});
  endtask

  // lay out one descriptor and queue what it must produce
  task automatic build_desc(input logic [15:0] off, input int n,
                            input logic [15:0] link, input logic [15:0] stat);
    int b;
    logic [15:0] cfg, sz;
    b   = int'(off) / 2;
    cfg = 16'hC000 | off;
    sz  = 16'd100 + off;
    mem[b] = 16'h0000;
    mem[b+1] = cfg;
    mem[b+2] = sz;
    mem[b+3] = 16'(n);
    if (n == 0) begin
      mem[b+5] = 16'hEEEE;
      mem[b+6] = 16'hEEEE;
    end
    for (int i = 0; i < n; i++) begin
      int f;
      logic [15:0] lo, hi, fs;
      f  = 4 + 3 * i;
      lo = 16'h1000 + off + 16'(i);
      hi = 16'h00B0 + 16'(i);
      fs = 16'd64 + 16'(8 * i);
      mem[b+f] = lo; mem[b+f+1] = hi; mem[b+f+2] = fs;
      exp_frag.push_back({hi, lo, fs, (i == n - 1)});
    end
    mem[b + 4 + 3 * n] = link;
    for (int k = 1; k <= 6; k++) push_acc(1'b0, off, k, 16'h0);
    for (int i = 1; i < n; i++)
      for (int k = 0; k < 3; k++) push_acc(1'b0, off, 4 + 3 * i + k, 16'h0);
    push_acc(1'b1, off, 0, (n == 0) ? ERR : stat);
    push_acc(1'b0, off, 4 + 3 * n, 16'h0);
    if (n > 0) exp_hdr.push_back({cfg, sz, 16'(n)});
  endtask

  task automatic run_chain(input int wn, input int rm);
    int p0, cyc;
    wait_n = wn; ready_mode = rm; p0 = pk; done_count = 0; acc_count = 0;
    build_desc(16'h0010, 1, 16'h0040, 16'h5000 + 16'(p0));
    build_desc(16'h0040, 3, 16'h0080, 16'h5000 + 16'(p0 + 1));
    build_desc(16'h0080, 0, 16'h00C0, 16'h0);
    build_desc(16'h00C0, 2, 16'h0001, 16'h5000 + 16'(p0 + 2));
    @(posedge clk); #2 desc_off = 16'h0010; start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    repeat (4) @(posedge clk);
    #2 desc_off = 16'h00C0; start = 1'b1;     // R10: ignored while busy
    @(posedge clk); #2 start = 1'b0;
    cyc = 0;
    while (done_count == 0 && cyc < 20000) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
    check("R8", "single list_done pulse", 64'(done_count), 64'd1);
    check("R10", "start while busy: access count", 64'(acc_count), 64'd41);
    check("R3", "access queue drained", 64'(exp_acc.size()), 64'd0);
    check("R4", "fragment queue drained", 64'(exp_frag.size()), 64'd0);
    check("R5", "header queue drained", 64'(exp_hdr.size()), 64'd0);
    check("R7", "status word desc 0x10", 64'(mem[8]), 64'(16'h5000 + 16'(p0)));
    check("R7", "status word desc 0xC0", 64'(mem[96]), 64'(16'h5000 + 16'(p0 + 2)));
    check("R9", "error status desc 0x80", 64'(mem[64]), 64'(ERR));
    check("R8", "busy low after end", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    check("R1", "busy in reset", 64'(busy), 64'd0);
    check("R1", "mem_req in reset", 64'(mem_req), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "outputs after reset",
          {59'd0, busy, mem_req, frag_valid, hdr_valid, list_done}, 64'd0);

    run_chain(0, 0);

    begin
      int a0;
      a0 = acc_count;
      @(posedge clk); #2 tx_done = 1'b1; tx_status = 16'hFFFF;
      @(posedge clk); #2 tx_done = 1'b0;
      repeat (6) @(negedge clk);
      check("R10", "stray tx_done: busy", 64'(busy), 64'd0);
      check("R10", "stray tx_done: no access", 64'(acc_count), 64'(a0));
      check("R10", "stray tx_done: status kept", 64'(mem[8]), 64'h5000);
    end

    run_chain(3, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule